// File: doc/BRIEF.md
# Memory-Map Chip-Select Decoder

This block turns the upper address lines of a 24-bit, word-oriented bus into one active-low select for each device in a small fixed memory map. The map has two ROM regions, one RAM region and two peripheral windows of two words each. Every address bit above a region's own offset bits is compared, so each device answers at exactly one place in the address space. A strobed access that lands outside every region raises a bus-error flag. The decoder never selects a device that merely shares some high bits with the address.

The address arrives as bits 23 down to 1, so every address is even and names one 16-bit word. A select or the error flag can change only while the active-low address strobe is asserted. A read/write flag (1 = read, 0 = write) protects the ROM regions. A strobed write to either ROM selects nothing and is reported as a bus error. The block is pure combinational logic with no clock and no state. It is meant to sit between the bus master's address outputs and the devices' enable pins.

Region bases and sizes are elaboration-time parameters. Select order in the vectors is fixed: index 0 is the first ROM, 1 is the RAM, 2 is the second ROM, 3 is peripheral 0 and 4 is peripheral 1.

Top module: `mmap_cs_decoder`

## Requirements
- R1: With the strobe low and a read, `cs_rom0_n_o` is low exactly for byte addresses 0x000000 to 0x000FFF (word addresses 0x000000 to 0x000FFE).
- R2: With the strobe low, `cs_ram_n_o` is low exactly for byte addresses 0x001000 to 0x001FFF, for both reads and writes.
- R3: With the strobe low and a read, `cs_rom1_n_o` is low exactly for byte addresses 0x004000 to 0x007FFF.
- R4: With the strobe low, `cs_per0_n_o` is low only at word addresses 0x008000 and 0x008002, and `cs_per1_n_o` is low only at 0x008004 and 0x008006.
- R5: At most one of the five select outputs is low at any time.
- R6: While `as_n_i` is high, all five selects are high and `bus_err_o` is low, whatever the address and `rw_i`.
- R7: A strobed access whose address lies in no region drives `bus_err_o` high and leaves every select high. The upper address bits never alias, so 0x800000 and 0x801000 are also unmapped.
- R8: A strobed write (`rw_i` = 0) to either ROM region asserts no select and drives `bus_err_o` high. A strobed read to a ROM selects it with `bus_err_o` low.
- R9: The outputs follow the inputs combinationally. There is no clock and no register between address or strobe and the outputs, so a change in the strobe removes a select or the error in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 23 | Address bits 23..1 (word address) |
| as_n_i | input | 1 | Address strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| cs_rom0_n_o | output | 1 | First ROM select, active low |
| cs_ram_n_o | output | 1 | RAM select, active low |
| cs_rom1_n_o | output | 1 | Second ROM select, active low |
| cs_per0_n_o | output | 1 | Peripheral 0 select, active low |
| cs_per1_n_o | output | 1 | Peripheral 1 select, active low |
| bus_err_o | output | 1 | Strobed access to no region, or ROM write |

## Verification
The embedded checks are immediate assertions, so they assume the address, strobe and direction inputs are settled when they are evaluated. They do not cover glitches that arise while inputs change. The stimulus therefore changes every input together on a clock edge and compares the outputs half a cycle later. Addresses are always driven as whole words, because bit 0 has no pin. The stimulus walks each region's first and last word and the word on either side of each boundary. It also covers addresses that differ from a mapped one only in high bits. Each of these addresses is applied as a read, as a write and with the strobe idle.

// File: rtl/mmap_cs_pkg.sv
// Package mmap_cs_pkg
// Shared constants for the chip-select decoder: region count, region
// indices, and the default map (byte bases, size in words as log2, ROM mask).
// Assumes a 24-bit byte address space with word-aligned accesses.
package mmap_cs_pkg;

    localparam int ADDR_W  = 24;
    localparam int NUM_REG = 5;
    localparam int LG2_W   = 5;

    typedef enum int {
        RG_ROM0 = 0,
        RG_RAM  = 1,
        RG_ROM1 = 2,
        RG_PER0 = 3,
        RG_PER1 = 4
    } region_e;

    // Byte base address per region, index 0 in the rightmost slot.
    localparam logic [NUM_REG-1:0][ADDR_W-1:0] MAP_BASE = {
        24'h008004,  // peripheral 1
        24'h008000,  // peripheral 0
        24'h004000,  // second ROM
        24'h001000,  // RAM
        24'h000000   // first ROM (holds the reset vectors)
    };

    // Region size as log2 of the number of 16-bit words.
    localparam logic [NUM_REG-1:0][LG2_W-1:0] MAP_WLG2 = {
        5'd1, 5'd1, 5'd13, 5'd11, 5'd11
    };

    // Regions that refuse writes.
    localparam logic [NUM_REG-1:0] MAP_ROM = 5'b00101;

endpackage

// File: rtl/mmap_region_match.sv
// Module mmap_region_match
// Reports whether a word address falls inside one naturally aligned region.
// All bits above the region's word-offset bits are compared, so the region
// never aliases. Assumes BASE is aligned to the region size.
module mmap_region_match #(
    parameter int                ADDR_W = 24,
    parameter logic [ADDR_W-1:0] BASE   = '0,
    parameter int                WLG2   = 1
) (
    input  logic [ADDR_W-1:1] addr_i,
    output logic              hit_o
);

    // Byte-level mask: ones on the bits that must equal the base.
    localparam logic [ADDR_W-1:0] MASK_FULL =
        ~((ADDR_W'(1) << (WLG2 + 1)) - ADDR_W'(1));
    localparam logic [ADDR_W-1:1] MASK = MASK_FULL[ADDR_W-1:1];
    localparam logic [ADDR_W-1:1] BASE_W = BASE[ADDR_W-1:1];

    // Compare every decoded bit against the base.
    always_comb begin
        hit_o = ((addr_i ^ BASE_W) & MASK) == '0;
    end

endmodule

// File: rtl/mmap_cs_qualify.sv
// Module mmap_cs_qualify
// Final decode stage: gates region hits with the address strobe, blocks
// writes to write-protected regions, and flags strobed accesses that
// resolve to no device. Assumes the hit vector is one-hot or zero.
module mmap_cs_qualify #(
    parameter int                 NUM_REG = 5,
    parameter logic [NUM_REG-1:0] RO_MASK = '0
) (
    input  logic [NUM_REG-1:0] hit_i,
    input  logic               as_n_i,
    input  logic               rw_i,
    output logic [NUM_REG-1:0] cs_n_o,
    output logic               bus_err_o
);

    logic [NUM_REG-1:0] allowed;

    // Drop hits on read-only regions during a write.
    always_comb begin
        allowed = rw_i ? hit_i : (hit_i & ~RO_MASK);
    end

    // Qualify with the strobe and raise the error for unresolved accesses.
    always_comb begin
        cs_n_o    = ~(allowed & {NUM_REG{~as_n_i}});
        bus_err_o = ~as_n_i && (allowed == '0);
    end

    // Checks on the qualified outputs against the raw inputs.
    always_comb begin
        AST_CS_ONEHOT: assert ($onehot0(~cs_n_o)) else $error("two selects low"); // R5
        AST_IDLE_QUIET: assert (!as_n_i || (&cs_n_o && !bus_err_o)) else $error("output while idle"); // R6
        AST_ERR_NO_CS: assert (!bus_err_o || &cs_n_o) else $error("error with select"); // R7
        AST_STROBE_RESOLVES: assert (as_n_i || bus_err_o || !(&cs_n_o)) else $error("strobe unanswered"); // R7
        AST_ROM_WRITE_BLOCKED: assert (rw_i || ((~cs_n_o & RO_MASK) == '0)) else $error("ROM write selected"); // R8
    end

endmodule

// File: rtl/mmap_cs_decoder.sv
// Module mmap_cs_decoder
// Fully decoded chip-select generator for a fixed five-region memory map.
// One matcher per region feeds the strobe-qualified select stage.
// Purely combinational; assumes word-aligned addresses (bit 0 not present).
module mmap_cs_decoder
    import mmap_cs_pkg::*;
#(
    parameter logic [NUM_REG-1:0][ADDR_W-1:0] REG_BASE = MAP_BASE,
    parameter logic [NUM_REG-1:0][LG2_W-1:0]  REG_WLG2 = MAP_WLG2,
    parameter logic [NUM_REG-1:0]             REG_ROM  = MAP_ROM
) (
    input  logic [ADDR_W-1:1] addr_i,
    input  logic              as_n_i,
    input  logic              rw_i,
    output logic              cs_rom0_n_o,
    output logic              cs_ram_n_o,
    output logic              cs_rom1_n_o,
    output logic              cs_per0_n_o,
    output logic              cs_per1_n_o,
    output logic              bus_err_o
);

    logic [NUM_REG-1:0] hit;
    logic [NUM_REG-1:0] cs_n;
    logic [ADDR_W-1:0]  byte_addr;

    // One full-decode matcher per region.
    for (genvar g = 0; g < NUM_REG; g++) begin : g_region
        mmap_region_match #(
            .ADDR_W (ADDR_W),
            .BASE   (REG_BASE[g]),
            .WLG2   (int'(REG_WLG2[g]))
        ) u_match (
            .addr_i (addr_i),
            .hit_o  (hit[g])
        );
    end

    mmap_cs_qualify #(
        .NUM_REG (NUM_REG),
        .RO_MASK (REG_ROM)
    ) u_qualify (
        .hit_i     (hit),
        .as_n_i    (as_n_i),
        .rw_i      (rw_i),
        .cs_n_o    (cs_n),
        .bus_err_o (bus_err_o)
    );

    // Fan the select vector out to named pins.
    always_comb begin
        cs_rom0_n_o = cs_n[RG_ROM0];
        cs_ram_n_o  = cs_n[RG_RAM];
        cs_rom1_n_o = cs_n[RG_ROM1];
        cs_per0_n_o = cs_n[RG_PER0];
        cs_per1_n_o = cs_n[RG_PER1];
    end

    // Rebuild the byte address for window checks.
    always_comb begin
        byte_addr = {addr_i, 1'b0};
    end

    // Each select only within its window, checked against the port address.
    always_comb begin
        AST_ROM0_WINDOW: assert (cs_rom0_n_o || byte_addr <= 24'h000FFF) else $error("rom0 out of window"); // R1
        AST_RAM_WINDOW: assert (cs_ram_n_o || (byte_addr >= 24'h001000 && byte_addr <= 24'h001FFF)) else $error("ram out of window"); // R2
        AST_ROM1_WINDOW: assert (cs_rom1_n_o || (byte_addr >= 24'h004000 && byte_addr <= 24'h007FFF)) else $error("rom1 out of window"); // R3
        AST_PER_WINDOW: assert ((cs_per0_n_o || byte_addr[23:2] == 22'h002000) && (cs_per1_n_o || byte_addr[23:2] == 22'h002001)) else $error("peripheral out of window"); // R4
    end

endmodule

// File: tb/mmap_cs_decoder_tb.sv
module mmap_cs_decoder_tb;

    localparam time TCLK = 4ns;

    typedef struct {
        logic [23:0] addr;
        logic        as_n;
        logic        rw;
        logic [4:0]  cs_n;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic [23:1] addr_i = '0;
    logic        as_n_i = 1'b1;
    logic        rw_i = 1'b1;
    logic        cs_rom0_n_o, cs_ram_n_o, cs_rom1_n_o, cs_per0_n_o, cs_per1_n_o, bus_err_o;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #(TCLK/2) clk = ~clk;

    mmap_cs_decoder u_dut (
        .addr_i      (addr_i),
        .as_n_i      (as_n_i),
        .rw_i        (rw_i),
        .cs_rom0_n_o (cs_rom0_n_o),
        .cs_ram_n_o  (cs_ram_n_o),
        .cs_rom1_n_o (cs_rom1_n_o),
        .cs_per0_n_o (cs_per0_n_o),
        .cs_per1_n_o (cs_per1_n_o),
        .bus_err_o   (bus_err_o)
    );

    // Region index from the requirement windows, -1 if unmapped.
    function automatic int region_of(logic [23:0] a);
        if (a <= 24'h000FFF) return 0;                        // R1
        if (a >= 24'h001000 && a <= 24'h001FFF) return 1;     // R2
        if (a >= 24'h004000 && a <= 24'h007FFF) return 2;     // R3
        if (a == 24'h008000 || a == 24'h008002) return 3;     // R4
        if (a == 24'h008004 || a == 24'h008006) return 4;     // R4
        return -1;                                            // R7
    endfunction

    // Driver: apply inputs on a rising edge and queue the expectation.
    task automatic drive(logic [23:0] a, logic as_n, logic rw);
        exp_t e;
        int   r;
        @(posedge clk);
        addr_i = a[23:1];
        as_n_i = as_n;
        rw_i   = rw;
        r      = region_of(a);
        e.addr = a; e.as_n = as_n; e.rw = rw;
        e.cs_n = 5'b11111;
        e.err  = 1'b0;
        if (as_n) begin
            e.tag = "R6";
        end else if (r < 0) begin
            e.err = 1'b1; e.tag = "R7";
        end else if (!rw && (r == 0 || r == 2)) begin
            e.err = 1'b1; e.tag = "R8";
        end else begin
            e.cs_n[r] = 1'b0;
            case (r)
                0: e.tag = "R1";
                1: e.tag = "R2";
                2: e.tag = "R3";
                default: e.tag = "R4";
            endcase
        end
        exp_q.push_back(e);
    endtask

    // Monitor: compare half a cycle after each drive (R9: no clocked delay).
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [4:0] got;
            e   = exp_q.pop_front();
            got = {cs_per1_n_o, cs_per0_n_o, cs_rom1_n_o, cs_ram_n_o, cs_rom0_n_o};
            n_cmp++;
            if (got !== e.cs_n || bus_err_o !== e.err) begin
                n_bad++;
                $display("FAIL %s/R9 addr=%h as_n=%b rw=%b: cs_n=%b err=%b expected cs_n=%b err=%b",
                         e.tag, e.addr, e.as_n, e.rw, got, bus_err_o, e.cs_n, e.err);
            end
            n_cmp++;
            if ($countones(~got) > 1) begin
                n_bad++;
                $display("FAIL R5 addr=%h: cs_n=%b expected at most one low", e.addr, got);
            end
        end
    end

    logic [23:0] pts [0:19] = '{
        24'h000000, 24'h000FFE, 24'h001000, 24'h001FFE, 24'h002000,
        24'h003FFE, 24'h004000, 24'h007FFE, 24'h008000, 24'h008002,
        24'h008004, 24'h008006, 24'h008008, 24'h007FFC, 24'h00FFFE,
        24'h800000, 24'h801000, 24'h408000, 24'hFFFFFE, 24'h000800
    };

    initial begin
        // Idle state first (R6).
        drive(24'h000000, 1'b1, 1'b1);
        for (int i = 0; i < 20; i++) drive(pts[i], 1'b0, 1'b1); // reads: R1-style windows
        for (int i = 0; i < 20; i++) drive(pts[i], 1'b0, 1'b0); // writes: R8
        for (int i = 0; i < 20; i++) drive(pts[i], 1'b1, 1'b0); // idle: R6
        // Strobe drop right after a hit clears it in the same cycle (R9).
        drive(24'h001000, 1'b0, 1'b1);
        drive(24'h001000, 1'b1, 1'b1);
        drive(24'h00FFFE, 1'b0, 1'b1);
        drive(24'h00FFFE, 1'b1, 1'b1);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(TCLK * 200000);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule